// File: doc/BRIEF.md
# JTAG TAP Bridge with User Instruction Space

This block is a JTAG test access port controller for a large chip. It lets custom logic in the fabric be written and read through the four JTAG pins. The controller runs the standard sixteen-state TAP state machine on TCK and keeps an 8-bit instruction register. It places the latched instruction on an output bus so that user logic can decode it.

When the latched instruction falls in the user range, the block steers data-register scans to the user side. It raises capture, shift and update indications for the user logic and forwards TCK and TDI to it. During these scans, TDO carries the bit that the user logic returns. Every other instruction selects a one-bit bypass register. The block also drives an active-low reset to the fabric whenever the controller is held in Test-Logic-Reset.

Top module: `jtag_user_tap`

## Requirements
- R1: From any state, five consecutive TCK rising edges with TMS high put the controller in Test-Logic-Reset. Four such edges starting from Shift-DR do not. One edge after Test-Logic-Reset is entered, `instr` reads 0xFF.
- R2: While `trstN` is low, and asynchronously to TCK, `userRstN` and `tdoEn` are 0 and `instr` is 0xFF. After release, normal scans work again.
- R3: Capture-IR loads 0x01 into the 8-bit instruction shift register. The first IR scan therefore presents the bits 1,0,0,0,0,0,0,0 on TDO in that order.
- R4: The instruction shifts in LSB first: TDI enters bit 7 and the register moves right. `instr` holds its old value during the shift. It takes the new value on the TCK edge that leaves Update-IR.
- R5: For `instr` values 0x10 to 0x7F inclusive, `drCapture`, `drShift` and `drUpdate` are high in Capture-DR, Shift-DR and Update-DR respectively. In Shift-DR, TDO returns `userTdo`. At most one of the three strobes is high at a time.
- R6: For `instr` values outside 0x10 to 0x7F (for example 0x0F, 0x80 or 0xFF), the three DR strobes stay low. A 1-bit bypass register captures 0 and then delays TDI by one shift.
- R7: `tdo` and `tdoEn` change only on falling TCK edges. `tdoEn` is 1 only in the low phase that follows entry into Shift-IR or Shift-DR and while the controller stays there.
- R8: `userRstN` is 0 while the controller is in Test-Logic-Reset or `trstN` is low. It is 1 in every other state.
- R9: `drClk` follows TCK and `userTdi` follows TDI with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| trstN | input | 1 | Asynchronous active-low TAP reset |
| userTdo | input | 1 | Serial bit returned by user logic |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdoEn | output | 1 | Output enable for the TDO pad |
| instr | output | 8 | Latched instruction |
| drClk | output | 1 | Data-register clock for user logic |
| drCapture | output | 1 | User DR capture indication |
| drShift | output | 1 | User DR shift indication |
| drUpdate | output | 1 | User DR update indication |
| userTdi | output | 1 | Forwarded serial data in |
| userRstN | output | 1 | Active-low reset to user logic |

## Verification
The bench scans opcodes on both sides of each edge of the user range: 0x0F, 0x10, 0x7F and 0x80. A comparison that is off by one would steer TDO to the wrong source and move the strobes to the wrong opcode.

The bench checks the bits shifted out during Capture-IR and the order in which the instruction bits enter. A wrong capture pattern or a reversed shift direction would show up as wrong TDO bits or a wrong latched opcode. It also checks that TDO holds across rising edges, which a design that updated TDO on the rising edge would break.

The bench leaves Shift-DR with exactly four and then five TMS-high edges, and it asserts TRST in the middle of a scan. A state machine with a wrong transition would either enter reset too early or fail to enter it at all.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_t;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapCtrl_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic     tck,
  input  logic     trstN,
  input  logic     tms,
  output tapCtrl_t ctrl
);

  tapState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    ctrl.inReset   = (state == ST_RESET);
    ctrl.captureIr = (state == ST_CAP_IR);
    ctrl.shiftIr   = (state == ST_SH_IR);
    ctrl.updateIr  = (state == ST_UPD_IR);
    ctrl.captureDr = (state == ST_CAP_DR);
    ctrl.shiftDr   = (state == ST_SH_DR);
    ctrl.updateDr  = (state == ST_UPD_DR);
  end

endmodule

// File: rtl/tap_regs.sv
module tap_regs
  import tap_pkg::*;
#(
  parameter int IR_W    = 8,
  parameter int USER_LO = 16,
  parameter int USER_HI = 127
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  logic            userTdo,
  input  tapCtrl_t        ctrl,
  output logic [IR_W-1:0] instr,
  output logic            drCapture,
  output logic            drShift,
  output logic            drUpdate,
  output logic            tdo,
  output logic            tdoEn
);

  localparam logic [IR_W-1:0] userLo     = IR_W'(USER_LO);
  localparam logic [IR_W-1:0] userHi     = IR_W'(USER_HI);
  localparam logic [IR_W-1:0] capPattern = {{(IR_W-2){1'b0}}, 2'b01};
  localparam logic [IR_W-1:0] bypassOp   = '1;

  logic [IR_W-1:0] irShift;
  logic            bypassBit;
  logic            userSel;
  logic            tdoNext;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              irShift <= '0;
    else if (ctrl.captureIr) irShift <= capPattern;
    else if (ctrl.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             instr <= bypassOp;
    else if (ctrl.inReset)  instr <= bypassOp;
    else if (ctrl.updateIr) instr <= irShift;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              bypassBit <= 1'b0;
    else if (ctrl.captureDr) bypassBit <= 1'b0;
    else if (ctrl.shiftDr)   bypassBit <= tdi;
  end

  assign userSel   = (instr >= userLo) && (instr <= userHi);
  assign drCapture = ctrl.captureDr & userSel;
  assign drShift   = ctrl.shiftDr & userSel;
  assign drUpdate  = ctrl.updateDr & userSel;

  assign tdoNext = ctrl.shiftIr ? irShift[0] : (userSel ? userTdo : bypassBit);

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= tdoNext;
      tdoEn <= ctrl.shiftIr | ctrl.shiftDr;
    end
  end

endmodule

// File: rtl/jtag_user_tap.sv
module jtag_user_tap
  import tap_pkg::*;
#(
  parameter int IR_W    = 8,
  parameter int USER_LO = 16,
  parameter int USER_HI = 127
) (
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  input  logic            trstN,
  input  logic            userTdo,
  output logic            tdo,
  output logic            tdoEn,
  output logic [IR_W-1:0] instr,
  output logic            drClk,
  output logic            drCapture,
  output logic            drShift,
  output logic            drUpdate,
  output logic            userTdi,
  output logic            userRstN
);

  tapCtrl_t ctrl;

  tap_fsm u_fsm (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .ctrl  (ctrl)
  );

  tap_regs #(
    .IR_W    (IR_W),
    .USER_LO (USER_LO),
    .USER_HI (USER_HI)
  ) u_regs (
    .tck       (tck),
    .trstN     (trstN),
    .tdi       (tdi),
    .userTdo   (userTdo),
    .ctrl      (ctrl),
    .instr     (instr),
    .drCapture (drCapture),
    .drShift   (drShift),
    .drUpdate  (drUpdate),
    .tdo       (tdo),
    .tdoEn     (tdoEn)
  );

  assign drClk    = tck;
  assign userTdi  = tdi;
  assign userRstN = trstN & ~ctrl.inReset;

endmodule

// File: rtl/tap_checker.sv
module tap_checker #(
  parameter int IR_W = 8
) (
  input logic            tck,
  input logic            trstN,
  input logic [IR_W-1:0] instr,
  input logic            drCapture,
  input logic            drShift,
  input logic            drUpdate,
  input logic            tdoEn,
  input logic            userRstN
);

  assert_reset_instr_R1: assert property (@(posedge tck) disable iff (!trstN)
    !userRstN |=> (instr == '1));

  assert_instr_stable_R4: assert property (@(posedge tck) disable iff (!trstN)
    drShift |=> $stable(instr));

  assert_strobe_onehot_R5: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({drCapture, drShift, drUpdate}));

  assert_update_pulse_R5: assert property (@(posedge tck) disable iff (!trstN)
    drUpdate |=> !drUpdate);

  assert_tdoen_shift_R7: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (!drCapture && !drUpdate));

endmodule

bind jtag_user_tap tap_checker #(.IR_W(IR_W)) u_chk (
  .tck       (tck),
  .trstN     (trstN),
  .instr     (instr),
  .drCapture (drCapture),
  .drShift   (drShift),
  .drUpdate  (drUpdate),
  .tdoEn     (tdoEn),
  .userRstN  (userRstN)
);

// File: tb/jtag_user_tap_test.sv
module jtag_user_tap_test;

  logic       tck = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       trstN = 1'b0;
  logic       userTdo;
  logic       tdo, tdoEn, drClk, drCapture, drShift, drUpdate, userTdi, userRstN;
  logic [7:0] instr;

  typedef struct {
    logic  val;
    string req;
  } expBit_t;

  expBit_t    expQ[$];
  int         total = 0;
  int         bad = 0;
  logic [2:0] ureg = 3'b000;
  logic [2:0] ulatch = 3'b000;

  jtag_user_tap uut (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN), .userTdo(userTdo),
    .tdo(tdo), .tdoEn(tdoEn), .instr(instr), .drClk(drClk),
    .drCapture(drCapture), .drShift(drShift), .drUpdate(drUpdate),
    .userTdi(userTdi), .userRstN(userRstN)
  );

  always #10 tck = ~tck;

  // user-side data register model: captures 101, shifts right from userTdi
  assign userTdo = ureg[0];
  always @(posedge drClk) begin
    if (drCapture)    ureg <= 3'b101;
    else if (drShift) ureg <= {userTdi, ureg[2:1]};
    if (drUpdate)     ulatch <= ureg;
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected TDO bit per enabled shift edge
  always @(posedge tck) begin
    expBit_t e;
    if (tdoEn) begin
      if (expQ.size() == 0) chk("R7", "tdoEn with no scan expected", 1, 0);
      else begin
        e = expQ.pop_front();
        chk(e.req, "tdo bit", int'(tdo), int'(e.val));
      end
    end
  end

  task automatic step(logic m, logic d);
    @(negedge tck);
    tms = m;
    tdi = d;
    @(posedge tck);
    #5;
  endtask

  task automatic irScan(logic [7:0] op);
    logic [7:0] prev;
    step(1, 0); step(1, 0); step(0, 0);  // Select-DR, Select-IR, Capture-IR
    step(0, 0);                          // Shift-IR
    chk("R7", "tdoEn still low right after entering Shift-IR", int'(tdoEn), 0);
    prev = instr;
    for (int i = 0; i < 8; i++) begin
      expQ.push_back('{val: (i == 0), req: "R3"});
      step(i == 7, op[i]);
      if (i == 0) chk("R7", "tdo held across rising edge", int'(tdo), 1);
      if (i == 3) chk("R4", "instr held during IR shift", int'(instr), int'(prev));
    end
    step(1, 0);                          // Update-IR
    step(0, 0);                          // Run-Test/Idle
    chk("R4", "instr after update", int'(instr), int'(op));
    chk("R7", "tdoEn low in idle", int'(tdoEn), 0);
  endtask

  task automatic drScan(logic [2:0] data, bit user);
    string rq;
    logic [2:0] cap;
    rq = user ? "R5" : "R6";
    cap = 3'b101;
    step(1, 0);
    step(0, 0);
    chk(rq, "drCapture in Capture-DR", int'(drCapture), int'(user));
    step(0, 0);
    chk(rq, "drShift in Shift-DR", int'(drShift), int'(user));
    for (int i = 0; i < 3; i++) begin
      expQ.push_back('{val: user ? cap[i] : ((i == 0) ? 1'b0 : data[i-1]), req: rq});
      step(i == 2, data[i]);
    end
    step(1, 0);
    chk(rq, "drUpdate in Update-DR", int'(drUpdate), int'(user));
    step(0, 0);
    chk("R5", "drUpdate low after Update-DR", int'(drUpdate), 0);
    if (user) chk("R5", "user register loaded", int'(ulatch), int'(data));
  endtask

  initial begin
    #35;
    chk("R2", "userRstN in TRST", int'(userRstN), 0);
    chk("R2", "instr in TRST", int'(instr), 8'hFF);
    chk("R8", "tdoEn in TRST", int'(tdoEn), 0);
    trstN = 1'b1;
    step(1, 0);
    chk("R8", "userRstN low in Test-Logic-Reset", int'(userRstN), 0);
    step(0, 1);
    chk("R8", "userRstN high in idle", int'(userRstN), 1);
    chk("R9", "userTdi follows tdi", int'(userTdi), 1);
    chk("R9", "drClk high with tck", int'(drClk), 1);
    @(negedge tck); #1;
    chk("R9", "drClk low with tck", int'(drClk), 0);

    irScan(8'h12); drScan(3'b110, 1); drScan(3'b011, 1);
    irScan(8'h0F); drScan(3'b101, 0);
    irScan(8'h10); drScan(3'b010, 1);
    irScan(8'h7F); drScan(3'b111, 1);
    irScan(8'h80); drScan(3'b011, 0);
    irScan(8'hFF); drScan(3'b100, 0);

    // R1: leave Shift-DR with TMS high
    irScan(8'h12);
    step(1, 0); step(0, 0); step(0, 0);
    expQ.push_back('{val: 1'b1, req: "R5"});
    for (int i = 0; i < 4; i++) step(1, 0);
    chk("R1", "not in reset after four TMS-high edges", int'(userRstN), 1);
    step(1, 0);
    chk("R1", "reset after fifth TMS-high edge", int'(userRstN), 0);
    step(1, 0);
    chk("R1", "instr is bypass in reset", int'(instr), 8'hFF);

    // R2: TRST in the middle of a user DR scan
    step(0, 0);
    irScan(8'h12);
    step(1, 0); step(0, 0); step(0, 0);
    @(negedge tck); #1;
    chk("R7", "tdoEn high in Shift-DR", int'(tdoEn), 1);
    trstN = 1'b0;
    #1;
    chk("R2", "userRstN async", int'(userRstN), 0);
    chk("R2", "instr async", int'(instr), 8'hFF);
    chk("R2", "tdoEn async", int'(tdoEn), 0);
    #3;
    trstN = 1'b1;
    expQ.delete();
    step(0, 0);
    irScan(8'h12); drScan(3'b001, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule